// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Lookup

This block is the load lookup path of a level-one data cache with 64 sets, 8 ways and 64-byte lines. A load presents only the page-offset bits of its virtual address. These bits are the same in the virtual and the physical address, so the block uses them to choose the set and start the tag read in the cycle the request is accepted. Translation runs in that same cycle. In the next cycle the translation stage delivers the physical page number, and the block compares it with the eight stored tags of the chosen set.

The response is registered. It comes out one cycle after the translation result and carries a hit flag, a cancel flag and the addressed 8-byte word. When a translation is missing or faulted, the lookup is cancelled. On a miss, the block holds a refill request that names the page and the set. It waits for a whole line on the fill port and writes that line into the way picked by a tree pseudo-LRU for the set.

The control is a three-state machine:
- IDLE accepts a request and reads the tags.
- LOOKUP compares the tags against the translation.
- REFILL waits for the line.

Its transitions are:
- IDLE to LOOKUP on an accepted request.
- LOOKUP to IDLE on a hit or a cancel.
- LOOKUP to REFILL on a miss.
- REFILL to IDLE when the fill arrives.

Top module: `vipt_l1d_lookup`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `resp_valid` and `miss_req` are 0, so the first lookup to any set misses.
- R2: The set index is `req_voff[8:3]` (virtual address bits 11:6) and the word within the line is `req_voff[2:0]` (address bits 5:3). A line cached under one set does not hit when the same page number is looked up in another set.
- R3: A lookup hits when a valid way of the selected set holds a tag equal to `xlat_ppn`, with `xlat_ppn` presented the cycle after acceptance. At most one way ever matches.
- R4: `resp_valid` pulses for exactly one cycle, on the second clock edge after the accepting edge. On a hit, `resp_data` is bits [64*w+63 : 64*w] of the stored line, where w is the word index.
- R5: If `xlat_valid` is 0 or `xlat_fault` is 1 in the translation cycle, the response has `resp_cancel`=1 and `resp_hit`=0. No refill is requested, and `req_ready` is 1 in the following cycle.
- R6: On a miss that is not cancelled, `miss_req` is 1 and holds `miss_ppn`=`xlat_ppn` and `miss_set` steady until `fill_valid`. While it waits, `req_ready` is 0 and requests are ignored.
- R7: The cycle with `fill_valid`=1 in REFILL writes `fill_line` into the victim way and returns the block to IDLE. A later lookup of that page and set hits and returns words of that line.
- R8: Each set keeps a 7-node binary tree, with nodes numbered 1 to 7 from the root and every node starting at 0. To find the victim, start at node 1 and move to child 2n+bit three times; the victim way is n-8. An access to way w walks the same path using bits w[2], w[1] and w[0], and sets each visited node to the inverse of the branch it takes. Hits and fills update the tree; cancels and misses do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Load request strobe |
| req_voff | input | 9 | Virtual address bits 11:3 (set index, word index) |
| req_ready | output | 1 | Block can accept a request |
| xlat_valid | input | 1 | Translation result present (cycle after acceptance) |
| xlat_fault | input | 1 | Translation raised a fault |
| xlat_ppn | input | 40 | Translated physical page number |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Lookup hit |
| resp_cancel | output | 1 | Lookup cancelled by translation |
| resp_data | output | 64 | Addressed 8-byte word on a hit, else zero |
| miss_req | output | 1 | Refill request pending |
| miss_ppn | output | 40 | Page number of the missing line |
| miss_set | output | 6 | Set of the missing line |
| fill_valid | input | 1 | Refill line delivered |
| fill_line | input | 512 | Refill line contents |

## Verification
The hardest behaviour to reach from the ports is the choice of victim in a full set whose tree has been reshaped by hits, cancels and earlier fills. The choice is visible only through which page later misses. The stimulus therefore fills one set to capacity, touches chosen ways, adds a ninth page, and then looks up the predicted victim. After that, dense random traffic uses twelve pages over three sets, so evictions recur. The bench also holds junk requests high during refill waits, to show that they are ignored.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_REFILL = 2'd2
    } vipt_state_e;
endpackage

// File: rtl/vipt_plru.sv
module vipt_plru #(
    parameter int SETS = 64,
    parameter int WAYS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  set_i,
    output logic [$clog2(WAYS)-1:0]  victim_way,
    input  logic                     upd_en,
    input  logic [$clog2(WAYS)-1:0]  upd_way
);
    localparam int LVL   = $clog2(WAYS);
    localparam int IDX_W = $clog2(SETS);

    logic [WAYS-2:0] tree_q [SETS];
    logic [WAYS-2:0] cur, nxt;

    assign cur = tree_q[set_i];

    always_comb begin
        int n;
        n = 1;
        for (int l = 0; l < LVL; l++) begin
            n = 2 * n + int'(cur[n-1]);
        end
        victim_way = LVL'(n - WAYS);
    end

    always_comb begin
        int n;
        logic d;
        nxt = cur;
        n = 1;
        for (int l = 0; l < LVL; l++) begin
            d = upd_way[LVL-1-l];
            nxt[n-1] = ~d;
            n = 2 * n + int'(d);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (upd_en) begin
            tree_q[set_i] <= nxt;
        end
    end

    // R8: the way just touched is never the next victim of the same set
    p_victim_not_recent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (victim_way != $past(upd_way)) || !$stable(set_i));

endmodule

// File: rtl/vipt_tag_array.sv
module vipt_tag_array #(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int PPN_W = 40
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic [$clog2(SETS)-1:0]         rd_set,
    output logic [WAYS-1:0][PPN_W-1:0]      rd_tags,
    output logic [WAYS-1:0]                 rd_vld,
    input  logic                            wr_en,
    input  logic [$clog2(SETS)-1:0]         wr_set,
    input  logic [$clog2(WAYS)-1:0]         wr_way,
    input  logic [PPN_W-1:0]                wr_tag
);
    logic [PPN_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
            rd_vld <= '0;
        end else begin
            if (wr_en) vld_q[wr_set][wr_way] <= 1'b1;
            if (rd_en) rd_vld <= vld_q[rd_set];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
        if (rd_en) begin
            for (int w = 0; w < WAYS; w++) rd_tags[w] <= tag_q[rd_set][w];
        end
    end
endmodule

// File: rtl/vipt_data_array.sv
module vipt_data_array #(
    parameter int SETS   = 64,
    parameter int WAYS   = 8,
    parameter int LINE_W = 512,
    parameter int WORD_W = 64
) (
    input  logic                                 clk,
    input  logic [$clog2(SETS)-1:0]              rd_set,
    input  logic [$clog2(WAYS)-1:0]              rd_way,
    input  logic [$clog2(LINE_W/WORD_W)-1:0]     rd_widx,
    output logic [WORD_W-1:0]                    rd_word,
    input  logic                                 wr_en,
    input  logic [$clog2(SETS)-1:0]              wr_set,
    input  logic [$clog2(WAYS)-1:0]              wr_way,
    input  logic [LINE_W-1:0]                    wr_line
);
    logic [LINE_W-1:0] line_q [SETS][WAYS];

    assign rd_word = line_q[rd_set][rd_way][int'(rd_widx)*WORD_W +: WORD_W];

    always_ff @(posedge clk) begin
        if (wr_en) line_q[wr_set][wr_way] <= wr_line;
    end
endmodule

// File: rtl/vipt_l1d_lookup.sv
module vipt_l1d_lookup
    import vipt_pkg::*;
#(
    parameter int SETS   = 64,
    parameter int WAYS   = 8,
    parameter int LINE_B = 64,
    parameter int WORD_B = 8,
    parameter int PPN_W  = 40,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WPL    = LINE_B / WORD_B,
    localparam int WI_W   = $clog2(WPL),
    localparam int WORD_W = WORD_B * 8,
    localparam int LINE_W = LINE_B * 8,
    localparam int VOFF_W = IDX_W + WI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VOFF_W-1:0] req_voff,
    output logic              req_ready,
    input  logic              xlat_valid,
    input  logic              xlat_fault,
    input  logic [PPN_W-1:0]  xlat_ppn,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_cancel,
    output logic [WORD_W-1:0] resp_data,
    output logic              miss_req,
    output logic [PPN_W-1:0]  miss_ppn,
    output logic [IDX_W-1:0]  miss_set,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line
);
    vipt_state_e state_q, state_d;

    logic [IDX_W-1:0]          set_q;
    logic [WI_W-1:0]           word_q;
    logic [PPN_W-1:0]          ppn_q;
    logic [WAYS-1:0][PPN_W-1:0] rd_tags;
    logic [WAYS-1:0]           rd_vld;
    logic [WAYS-1:0]           way_match;
    logic [WAY_W-1:0]          hit_way, victim_way, upd_way;
    logic [WORD_W-1:0]         rd_word;
    logic                      accept, cancel, lookup_hit, fill_fire;

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign cancel     = !xlat_valid || xlat_fault;
    assign lookup_hit = (state_q == ST_LOOKUP) && !cancel && (|way_match);
    assign fill_fire  = (state_q == ST_REFILL) && fill_valid;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_match[w] = rd_vld[w] && (rd_tags[w] == xlat_ppn);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w]) hit_way = WAY_W'(w);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = (cancel || lookup_hit) ? ST_IDLE : ST_REFILL;
            ST_REFILL: if (fill_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request context held across the lookup and refill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q  <= '0;
            word_q <= '0;
            ppn_q  <= '0;
        end else begin
            if (accept) begin
                set_q  <= req_voff[VOFF_W-1:WI_W];
                word_q <= req_voff[WI_W-1:0];
            end
            if (state_q == ST_LOOKUP) ppn_q <= xlat_ppn;
        end
    end

    // registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_cancel <= 1'b0;
            resp_data   <= '0;
        end else begin
            resp_valid  <= (state_q == ST_LOOKUP);
            resp_hit    <= lookup_hit;
            resp_cancel <= (state_q == ST_LOOKUP) && cancel;
            resp_data   <= lookup_hit ? rd_word : '0;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign miss_req  = (state_q == ST_REFILL);
    assign miss_ppn  = ppn_q;
    assign miss_set  = set_q;
    assign upd_way   = fill_fire ? victim_way : hit_way;

    vipt_tag_array #(.SETS(SETS), .WAYS(WAYS), .PPN_W(PPN_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (accept),
        .rd_set  (req_voff[VOFF_W-1:WI_W]),
        .rd_tags (rd_tags),
        .rd_vld  (rd_vld),
        .wr_en   (fill_fire),
        .wr_set  (set_q),
        .wr_way  (victim_way),
        .wr_tag  (ppn_q)
    );

    vipt_data_array #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
        .clk     (clk),
        .rd_set  (set_q),
        .rd_way  (hit_way),
        .rd_widx (word_q),
        .rd_word (rd_word),
        .wr_en   (fill_fire),
        .wr_set  (set_q),
        .wr_way  (victim_way),
        .wr_line (fill_line)
    );

    vipt_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_q),
        .victim_way (victim_way),
        .upd_en     (lookup_hit || fill_fire),
        .upd_way    (upd_way)
    );

    // R3: never more than one way matches the translated page
    p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> $onehot0(way_match));

    // R4: an accepted request gets its response two edges later
    p_resp_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 resp_valid);

    // R5: a cancelled lookup reports no hit and leaves the block ready
    p_cancel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_cancel) |-> (!resp_hit && req_ready && !miss_req));

    // R6: refill request holds steady and blocks new requests
    p_miss_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && !fill_valid) |=> (miss_req && $stable(miss_ppn) && $stable(miss_set)));

    p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> !req_ready);

    // R7: a delivered fill returns the block to accepting requests
    p_fill_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && fill_valid) |=> req_ready);

endmodule

// File: tb/test_vipt_l1d_lookup.sv
module test_vipt_l1d_lookup;
    localparam int SETS = 64;
    localparam int WAYS = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [8:0]   req_voff = '0;
    logic         req_ready;
    logic         xlat_valid = 1'b0;
    logic         xlat_fault = 1'b0;
    logic [39:0]  xlat_ppn = '0;
    logic         resp_valid, resp_hit, resp_cancel;
    logic [63:0]  resp_data;
    logic         miss_req;
    logic [39:0]  miss_ppn;
    logic [5:0]   miss_set;
    logic         fill_valid = 1'b0;
    logic [511:0] fill_line = '0;

    always #10 clk = ~clk;

    vipt_l1d_lookup i_vipt_l1d_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_voff(req_voff),
        .req_ready(req_ready), .xlat_valid(xlat_valid), .xlat_fault(xlat_fault),
        .xlat_ppn(xlat_ppn), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_cancel(resp_cancel), .resp_data(resp_data), .miss_req(miss_req),
        .miss_ppn(miss_ppn), .miss_set(miss_set), .fill_valid(fill_valid),
        .fill_line(fill_line)
    );

    int checks = 0;
    int fails  = 0;
    bit exp_rv = 1'b0;
    bit done   = 1'b0;
    int cyc    = 0;

    // behavioural model: per set, per way valid and page; tree bits per set
    bit          m_vld  [SETS][WAYS];
    logic [39:0] m_tag  [SETS][WAYS];
    bit   [6:0]  m_tree [SETS];

    function automatic logic [63:0] word_of(logic [39:0] p, int s, int k);
        return {16'hC3A0 ^ 16'(k), 8'(s), p};
    endfunction

    function automatic logic [511:0] line_of(logic [39:0] p, int s);
        logic [511:0] l;
        for (int k = 0; k < 8; k++) l[k*64 +: 64] = word_of(p, s, k);
        return l;
    endfunction

    function automatic int m_victim(int s);
        int n = 1;
        for (int l = 0; l < 3; l++) n = 2 * n + int'(m_tree[s][n-1]);
        return n - 8;
    endfunction

    task automatic m_touch(int s, int w);
        int n = 1;
        for (int l = 0; l < 3; l++) begin
            int d = (w >> (2 - l)) & 1;
            m_tree[s][n-1] = (d == 0);
            n = 2 * n + d;
        end
    endtask

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // every-cycle comparison of the response strobe (R4)
    always @(posedge clk) begin
        #5;
        if (rst_n && !done)
            check(resp_valid === exp_rv, "R4", "resp_valid per cycle", 64'(resp_valid), 64'(exp_rv));
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // one load; returns whether it hit
    task automatic load(int s, int k, logic [39:0] p, bit xv, bit xf, int junk, output bit was_hit);
        bit cancel, hit;
        int hw, v;
        @(negedge clk);
        check(req_ready === 1'b1, "R7", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_voff  = {6'(s), 3'(k)};
        @(negedge clk);
        req_valid  = 1'b0;
        xlat_valid = xv;
        xlat_fault = xf;
        xlat_ppn   = p;
        exp_rv     = 1'b1;
        @(negedge clk);
        exp_rv     = 1'b0;
        xlat_valid = 1'b0;
        xlat_fault = 1'b0;
        cancel = !xv || xf;
        hit = 1'b0;
        hw  = 0;
        for (int w = 0; w < WAYS; w++)
            if (m_vld[s][w] && m_tag[s][w] == p) begin hit = 1'b1; hw = w; end
        hit = hit && !cancel;
        was_hit = hit;
        check(resp_cancel === cancel, "R5", "resp_cancel", 64'(resp_cancel), 64'(cancel));
        check(resp_hit === hit, "R3", "resp_hit", 64'(resp_hit), 64'(hit));
        if (hit) begin
            check(resp_data === word_of(p, s, k), "R4", "resp_data", resp_data, word_of(p, s, k));
            m_touch(s, hw);
        end
        if (cancel) begin
            check(req_ready === 1'b1 && miss_req === 1'b0, "R5", "no refill after cancel",
                  64'({req_ready, miss_req}), 64'b10);
        end else if (!hit) begin
            check(miss_req === 1'b1 && miss_ppn === p && miss_set === 6'(s), "R6", "refill request",
                  {miss_req, 17'd0, miss_set, miss_ppn}, {1'b1, 17'd0, 6'(s), p});
            for (int j = 0; j < junk; j++) begin
                req_valid = 1'b1;
                req_voff  = 9'($urandom);
                @(negedge clk);
                check(miss_req === 1'b1 && req_ready === 1'b0 && miss_ppn === p, "R6",
                      "request ignored during refill", 64'({miss_req, req_ready}), 64'b10);
            end
            req_valid  = 1'b0;
            fill_valid = 1'b1;
            fill_line  = line_of(p, s);
            @(negedge clk);
            fill_valid = 1'b0;
            check(req_ready === 1'b1 && miss_req === 1'b0, "R7", "idle after fill",
                  64'({req_ready, miss_req}), 64'b10);
            v = m_victim(s);
            m_vld[s][v] = 1'b1;
            m_tag[s][v] = p;
            m_touch(s, v);
        end
    endtask

    function automatic logic [39:0] page(int i);
        return 40'hA5_0000_0000 ^ (40'(i) * 40'h13_5791);
    endfunction

    initial begin
        bit h;
        int e;
        logic [39:0] evicted;
        for (int s = 0; s < SETS; s++) begin
            m_tree[s] = '0;
            for (int w = 0; w < WAYS; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
        end
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(req_ready === 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        check(resp_valid === 1'b0 && miss_req === 1'b0, "R1", "idle outputs after reset",
              64'({resp_valid, miss_req}), 64'd0);
        rst_n = 1'b1;

        // R1: first lookup misses; then fill set 9 to capacity (R7)
        for (int i = 0; i < 8; i++) begin
            load(9, i, page(i), 1'b1, 1'b0, 1, h);
            check(h == 1'b0, "R1", "cold lookup misses", 64'(h), 64'd0);
        end
        // R3/R4: all eight resident pages hit, each word index
        for (int i = 0; i < 8; i++) begin
            load(9, 7 - i, page(i), 1'b1, 1'b0, 0, h);
            check(h == 1'b1, "R7", "filled line hits", 64'(h), 64'd1);
        end
        // R2: same page in a different set is a separate line
        load(10, 2, page(0), 1'b1, 1'b0, 2, h);
        check(h == 1'b0, "R2", "page cached in other set misses", 64'(h), 64'd0);
        load(10, 5, page(0), 1'b1, 1'b0, 0, h);
        // R5: fault and absent translation cancel, also for a resident page
        load(9, 1, page(1), 1'b1, 1'b1, 0, h);
        load(9, 1, page(1), 1'b0, 1'b0, 0, h);
        load(9, 3, page(40), 1'b1, 1'b1, 0, h);
        // R8: touch some ways, then overflow set 9 and look up the predicted victim
        load(9, 0, page(3), 1'b1, 1'b0, 0, h);
        load(9, 0, page(6), 1'b1, 1'b0, 0, h);
        e = m_victim(9);
        evicted = m_tag[9][e];
        load(9, 4, page(8), 1'b1, 1'b0, 0, h);
        load(9, 4, evicted, 1'b1, 1'b0, 0, h);
        check(h == 1'b0, "R8", "predicted victim was evicted", 64'(h), 64'd0);
        load(9, 6, page(8), 1'b1, 1'b0, 0, h);
        check(h == 1'b1, "R8", "new page kept after victim refill", 64'(h), 64'd1);

        // mixed traffic: 12 pages over 3 sets, with faults and absent translations
        for (int t = 0; t < 220; t++) begin
            int sel, s, r;
            bit xv, xf;
            sel = int'($urandom_range(0, 2));
            s = (sel == 0) ? 0 : (sel == 1) ? 9 : 63;
            r = int'($urandom_range(0, 99));
            xv = (r >= 5);
            xf = (r >= 5 && r < 15);
            load(s, int'($urandom_range(0, 7)), page(int'($urandom_range(0, 11))), xv, xf,
                 int'($urandom_range(0, 2)), h);
        end

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule